// File: doc/BRIEF.md
# Read-Only Serial Register Slave with Auto-Increment

This block is a two-wire serial bus slave that only supports read transfers. It offers a small bank of byte registers to a bus master. A fast system clock oversamples the clock line and the data line. Both lines pass through a synchronizer before the block looks for edges, start conditions and stop conditions. When the master sends the block's 7-bit device address with the read bit set, the block acknowledges. It then shifts out register bytes one after another, most significant bit first.

The master cannot pick the starting byte. An internal byte pointer returns to the first byte on every start condition, including a repeated start. Only a master acknowledge moves the pointer forward. Register contents arrive on a flat parallel input, together with a count of valid bytes. Bytes read past that count come out as all ones, with the data line left released. The block never drives the data line high. It only pulls the line low through an output-enable, and the board forms the bus as a wired-AND of all drivers.

Top module: `i2c_rd_slave`

## Requirements
- R1: After reset the block does not pull the data line low, and it stays silent until it is addressed.
- R2: The data line falling while the clock line is high is a start condition. It begins address reception and sets the byte pointer to byte 0, which is regBank[7:0].
- R3: The eight bits after a start are the 7-bit address, most significant bit first, followed by the direction bit. If the address equals DEV_ADDR and the direction bit is 1, the block holds the data line low for the whole ninth clock pulse.
- R4: If the address differs, or the direction bit is 0, the block does not acknowledge. It then leaves the data line released until the next start or stop condition.
- R5: Each data byte goes out over eight clock pulses, most significant bit first. Byte k is regBank[8k+7:8k].
- R6: A master acknowledge (data line low on the ninth pulse) advances the pointer by one. The next byte follows at once.
- R7: A byte whose index is byteCount or higher reads as 0xFF, and the block keeps the data line released for all of it. The pointer stops at MAX_BYTES.
- R8: A master not-acknowledge ends transmission, and the data line stays released. The next transfer starts again at byte 0.
- R9: A repeated start in the middle of a read sets the pointer back to byte 0 and restarts address reception.
- R10: The data line rising while the clock line is high is a stop condition. It returns the block to idle with the data line released.
- R11: The pull-down output changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level, as resolved by the wired-AND |
| regBank | input | MAX_BYTES*8 | Register bytes, with byte k at bits [8k+7:8k] |
| byteCount | input | $clog2(MAX_BYTES+1) | Number of valid bytes, 1 to MAX_BYTES |
| sdaPullLow | output | 1 | Output-enable that pulls the data line low when high |

## Verification
The assertions assume three things about the inputs:
- Both bus lines hold each level for many system clocks, longer than the synchronizer delay.
- The master changes the data line only while the clock line is low, except when it makes a start or stop condition.
- byteCount stays within 1 to MAX_BYTES and does not change during a transfer.

The bench keeps to these rules. It uses a bus master built from tasks, with every bus phase lasting sixteen system clocks. It changes the data line only in the low phase, and it changes byteCount only between transfers, while the bus is idle. The bench makes a repeated start only after the slave has released the line for a byte whose top bit is 1.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef struct packed {
    logic clearPtr;
    logic incPtr;
    logic shiftAddr;
    logic ackDrive;
    logic loadByte;
    logic shiftOut;
    logic releaseSda;
  } strobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ADDR_ACK,
    ST_SEND,
    ST_HOST_ACK,
    ST_RELOAD,
    ST_IGNORE
  } busState_t;

endpackage

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic     addrOk,
  output strobes_t strb,
  output logic     sclLvl,
  output logic     sdaLvl
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t state, stateNxt;
  logic [2:0] bitCnt, cntNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl    = sclPipe[SYNC_STAGES-1];
  assign sdaLvl    = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    cntNxt   = bitCnt;
    if (startSeen) begin
      stateNxt        = ST_ADDR;
      cntNxt          = '0;
      strb.clearPtr   = 1'b1;
      strb.releaseSda = 1'b1;
    end else if (stopSeen) begin
      stateNxt        = ST_IDLE;
      strb.releaseSda = 1'b1;
    end else begin
      case (state)
        ST_ADDR: if (sclRise) begin
          strb.shiftAddr = 1'b1;
          cntNxt         = bitCnt + 3'd1;
          if (bitCnt == 3'd7) stateNxt = ST_ADDR_END;
        end
        ST_ADDR_END: if (sclFall) begin
          if (addrOk) begin
            strb.ackDrive = 1'b1;
            stateNxt      = ST_ADDR_ACK;
          end else begin
            stateNxt = ST_IGNORE;
          end
        end
        ST_ADDR_ACK, ST_RELOAD: if (sclFall) begin
          strb.loadByte = 1'b1;
          cntNxt        = '0;
          stateNxt      = ST_SEND;
        end
        ST_SEND: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            strb.releaseSda = 1'b1;
            stateNxt        = ST_HOST_ACK;
          end else begin
            strb.shiftOut = 1'b1;
            cntNxt        = bitCnt + 3'd1;
          end
        end
        ST_HOST_ACK: if (sclRise) begin
          if (!sdaLvl) begin
            strb.incPtr = 1'b1;
            stateNxt    = ST_RELOAD;
          end else begin
            stateNxt = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= cntNxt;
    end
  end

  // R10: a stop condition always lands in idle
  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> state == ST_IDLE);

  // R4: after a rejected address, no acknowledge and no data load
  a_r4_ignore_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> (!strb.ackDrive && !strb.loadByte));

  // R5: at most one action on the line driver per cycle
  a_r5_one_drive_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ackDrive, strb.loadByte, strb.shiftOut, strb.releaseSda}));

endmodule

// File: rtl/i2c_rd_dpath.sv
module i2c_rd_dpath
  import i2c_rd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter int         MAX_BYTES = 16,
  localparam int        CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strb,
  input  logic                   sdaLvl,
  input  logic [MAX_BYTES*8-1:0] regBank,
  input  logic [CNT_W-1:0]       byteCount,
  output logic                   addrOk,
  output logic                   drvLow
);

  logic [7:0] addrShift, txShift, curByte;
  logic [CNT_W-1:0] ptr;

  always_comb begin
    curByte = 8'hFF;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (ptr == CNT_W'(i) && CNT_W'(i) < byteCount) curByte = regBank[i*8 +: 8];
    end
  end

  assign addrOk = (addrShift[7:1] == DEV_ADDR) && addrShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShift <= '0;
      txShift   <= '1;
      ptr       <= '0;
      drvLow    <= 1'b0;
    end else begin
      if (strb.shiftAddr) addrShift <= {addrShift[6:0], sdaLvl};
      if (strb.clearPtr) ptr <= '0;
      else if (strb.incPtr && ptr != CNT_W'(MAX_BYTES)) ptr <= ptr + CNT_W'(1);
      if (strb.releaseSda) drvLow <= 1'b0;
      else if (strb.ackDrive) drvLow <= 1'b1;
      else if (strb.loadByte) begin
        drvLow  <= ~curByte[7];
        txShift <= {curByte[6:0], 1'b1};
      end else if (strb.shiftOut) begin
        drvLow  <= ~txShift[7];
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  // R2: a start leaves the pointer on byte 0
  a_r2_start_clears_ptr: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearPtr |=> ptr == '0);

  // R6: a master acknowledge steps the pointer by one below the ceiling
  a_r6_ack_steps_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && !strb.clearPtr && ptr != CNT_W'(MAX_BYTES)) |=> ptr == $past(ptr) + CNT_W'(1));

  // R7: bytes beyond the valid count never pull the line
  a_r7_filler_released: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadByte && ptr >= byteCount) |=> !drvLow);

endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
  import i2c_rd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         MAX_BYTES   = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [MAX_BYTES*8-1:0] regBank,
  input  logic [CNT_W-1:0]       byteCount,
  output logic                   sdaPullLow
);

  strobes_t strb;
  logic sclLvl, sdaLvl, addrOk;

  i2c_rd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrOk(addrOk), .strb(strb), .sclLvl(sclLvl), .sdaLvl(sdaLvl)
  );

  i2c_rd_dpath #(.DEV_ADDR(DEV_ADDR), .MAX_BYTES(MAX_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(sdaLvl),
    .regBank(regBank), .byteCount(byteCount),
    .addrOk(addrOk), .drvLow(sdaPullLow)
  );

  // R11: the pull-down moves only while the synchronized clock line is low
  a_r11_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclLvl);

endmodule

// File: tb/i2c_rd_slave_test.sv
module i2c_rd_slave_test;
  localparam int MAX_BYTES = 16;
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [MAX_BYTES*8-1:0] regBank;
  logic [CNT_W-1:0] byteCount;
  logic sdaPullLow;
  wire sdaBus = sdaM & ~sdaPullLow;

  int checks = 0;
  int failures = 0;
  int badDrive = 0;
  int silentViol = 0;
  bit armed = 1'b0;
  bit silentWin = 1'b0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] rxByte;
  event rxEv;

  always #5 clk = ~clk;

  i2c_rd_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .regBank(regBank), .byteCount(byteCount), .sdaPullLow(sdaPullLow)
  );

  function automatic logic [7:0] bankByte(int k);
    return 8'(8'h3C + k * 8'h47);
  endfunction

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expectation per received byte
  always @(rxEv) begin
    if (expQ.size() == 0) begin
      checks++;
      failures++;
      $display("FAIL R5 unexpected byte actual=%0h expected=none", rxByte);
    end else begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      checkEq(t, 32'(rxByte), 32'(e));
    end
  end

  always @(sdaPullLow) if (armed && sclM !== 1'b0) badDrive++;
  always @(negedge clk) if (silentWin && sdaPullLow) silentViol++;

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b0; qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b1; qwait();
  endtask

  task automatic clockBit(input bit b, output bit r);
    sdaM = b; qwait();
    sclM = 1'b1; qwait();
    #1 r = sdaBus;
    qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic sendAddr(input logic [6:0] a, input bit rw, output bit ack);
    logic [7:0] v;
    bit r;
    v = {a, rw};
    for (int i = 7; i >= 0; i--) clockBit(v[i], r);
    clockBit(1'b1, r);
    ack = !r;
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] d);
    bit r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, r);
      d = {d[6:0], r};
    end
    clockBit(!ackIt, r);
  endtask

  task automatic readBurst(input int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      readByte(k < n - 1, d);
      rxByte = d;
      ->rxEv;
      #1;
    end
  endtask

  task automatic pushExp(logic [7:0] d, string tag);
    expQ.push_back(d);
    tagQ.push_back(tag);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    for (int k = 0; k < MAX_BYTES; k++) regBank[k*8 +: 8] = bankByte(k);
    byteCount = CNT_W'(6);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1 reset release", 32'(sdaPullLow), 0);
    armed = 1'b1;

    // plain read of four bytes
    busStart();
    sendAddr(ADDR, 1'b1, ack);
    checkEq("R3 address ack", 32'(ack), 1);
    pushExp(bankByte(0), "R5 first byte");
    pushExp(bankByte(1), "R6 second byte");
    pushExp(bankByte(2), "R6 third byte");
    pushExp(bankByte(3), "R6 fourth byte");
    readBurst(4);
    checkEq("R8 released after nack", 32'(sdaPullLow), 0);
    busStop();
    checkEq("R10 idle after stop", 32'(sdaPullLow), 0);

    // a new transfer restarts at byte 0
    busStart();
    sendAddr(ADDR, 1'b1, ack);
    checkEq("R2 ack second transfer", 32'(ack), 1);
    pushExp(bankByte(0), "R8 restart at byte 0");
    pushExp(bankByte(1), "R8 restart next");
    readBurst(2);
    busStop();

    // bytes past the valid count
    byteCount = CNT_W'(3);
    busStart();
    sendAddr(ADDR, 1'b1, ack);
    checkEq("R3 ack short bank", 32'(ack), 1);
    for (int k = 0; k < 3; k++) pushExp(bankByte(k), "R6 valid byte");
    for (int k = 0; k < 3; k++) pushExp(8'hFF, "R7 filler byte");
    readBurst(6);
    busStop();

    // full bank plus one, pointer ceiling
    byteCount = CNT_W'(16);
    busStart();
    sendAddr(ADDR, 1'b1, ack);
    for (int k = 0; k < 16; k++) pushExp(bankByte(k), "R6 full bank");
    pushExp(8'hFF, "R7 past ceiling");
    readBurst(17);
    busStop();

    // wrong address
    byteCount = CNT_W'(6);
    busStart();
    silentWin = 1'b1;
    sendAddr(7'h2B, 1'b1, ack);
    checkEq("R4 no ack wrong address", 32'(ack), 0);
    readByte(1'b1, d);
    checkEq("R4 silent after mismatch", 32'(d), 32'hFF);
    silentWin = 1'b0;
    busStop();

    // write direction
    busStart();
    silentWin = 1'b1;
    sendAddr(ADDR, 1'b0, ack);
    checkEq("R4 no ack write bit", 32'(ack), 0);
    readByte(1'b0, d);
    checkEq("R4 silent after write bit", 32'(d), 32'hFF);
    silentWin = 1'b0;
    busStop();
    checkEq("R4 no pull in silent windows", 32'(silentViol), 0);

    // repeated start while byte 2 (top bit 1) is presented
    busStart();
    sendAddr(ADDR, 1'b1, ack);
    readByte(1'b1, d);
    checkEq("R5 byte before restart", 32'(d), 32'(bankByte(0)));
    readByte(1'b1, d);
    checkEq("R6 byte before restart", 32'(d), 32'(bankByte(1)));
    busStart();
    sendAddr(ADDR, 1'b1, ack);
    checkEq("R9 ack after repeated start", 32'(ack), 1);
    pushExp(bankByte(0), "R9 pointer back to byte 0");
    readBurst(1);
    busStop();
    checkEq("R10 released at end", 32'(sdaPullLow), 0);

    checkEq("R11 drive changes only with clock low", 32'(badDrive), 0);
    checkEq("R5 scoreboard drained", 32'(expQ.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule